// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is one eight-pin general-purpose I/O port driven from a small register bus. Each pin has its own direction bit and its own output-latch bit. A pin whose direction bit is 1 is an input, and its output enable is held low. A pin whose direction bit is 0 drives its latch bit onto the pad. Pad levels pass through a two-flop synchronizer before software can read them.

Software reads the pad levels and the output latch at different addresses. A read-modify-write sequence that goes through the latch address works on the values the port intends to drive. It does not see whatever level is on the pads. A write to either the pin address or the latch address loads the output latch.

A mode input hands the pads to an external parallel-slave-port engine. While that input is high, the engine's data and enable inputs drive the pads. Register writes still land in the latch and direction registers. Those values take effect once the mode input drops.

Register map (2-bit address): 0 = pin levels (a read returns the synchronized pads, a write loads the latch), 1 = output latch, 2 = direction (1 = input), 3 = unused (reads 0, writes ignored).

Top module: `gpio_bidir_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0x00 and every pin output enable is 0.
- R2: Outside slave-port mode, a pin whose direction bit is 1 has its output enable at 0.
- R3: Outside slave-port mode, a pin whose direction bit is 0 has its output enable at 1. Every pin's output value equals its latch bit.
- R4: A read of address 1 returns the output latch, whatever the pad levels are.
- R5: A read of address 0 returns the pad levels through a two-flop synchronizer. A pad change made before clock edge k first shows up after edge k+1.
- R6: A selected write to address 0 or address 1 loads the write data into the output latch on the next clock edge. A write to address 2 loads the direction register.
- R7: While slave-port mode is high, the pin output values equal the engine data inputs and the pin output enables equal the engine enable inputs.
- R8: Writes made while slave-port mode is high update the latch and direction registers. Those values drive the pins once the mode input is low.
- R9: Address 3 reads as 0x00. A write to address 3 changes neither the latch nor the direction register.
- R10: With bus select low, a write changes no register. Read data is 0 unless the bus is selected for a read.
- R11: Writing 0xCF to the direction register enables outputs on pins 5:4 only (output enable = 0x30).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus select |
| bus_wr | input | 1 | Write enable (1 = write, 0 = read) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables (1 = drive) |
| psp_mode | input | 1 | Hands the pads to the slave-port engine |
| psp_dout | input | 8 | Engine output data |
| psp_oe | input | 8 | Engine output enables |

## Verification
Directed cases cover the reset values and the mixed direction pattern 0xCF. They also check a latch read against opposite pad levels, which separates the latch path from the pad path. A pad change is sampled one edge and two edges later, which checks the synchronizer depth. Random writes go to all four addresses, with bus select sometimes low and slave-port mode switched on and off. After each write, the pins and a random register read are compared with a model. These cases separate writes that are ignored, writes to the wrong register and a pad mux stuck on one source.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PINS  = 2'd0,
        REG_LATCH = 2'd1,
        REG_DIR   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] settle_d, settle_q;
            always_comb settle_d = (settle_q == 2'd2) ? settle_q : settle_q + 2'd1;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) settle_q <= '0;
                else        settle_q <= settle_d;
            end
            AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
                (settle_q == 2'd2) |-> (sync_out == $past(async_in, 2))); // R5
        end
    endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  latch_q_o,
    output logic [WIDTH-1:0]  dir_q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] latch;
        logic [WIDTH-1:0] dir;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_en;

    always_comb begin
        regs_d = regs_q;
        wr_en  = bus_sel && bus_wr;
        if (wr_en) begin
            unique case (reg_sel_e'(bus_addr))
                REG_PINS, REG_LATCH: regs_d.latch = bus_wdata;
                REG_DIR:             regs_d.dir   = bus_wdata;
                default:             ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.latch <= '0;
            regs_q.dir   <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign latch_q_o = regs_q.latch;
    assign dir_q_o   = regs_q.dir;

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == REG_PINS || bus_addr == REG_LATCH))
        |=> (latch_q_o == $past(bus_wdata))); // R6
    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_DIR) |=> (dir_q_o == $past(bus_wdata))); // R6
    AST_UNUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == REG_NONE) |=> ($stable(latch_q_o) && $stable(dir_q_o))); // R9
    AST_NO_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel) |=> ($stable(latch_q_o) && $stable(dir_q_o))); // R10
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int WIDTH = 8
) (
    input  logic             psp_mode,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] psp_dout,
    input  logic [WIDTH-1:0] psp_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            always_comb begin
                if (psp_mode) begin
                    pin_out[p] = psp_dout[p];
                    pin_oe[p]  = psp_oe[p];
                end else begin
                    pin_out[p] = latch_q[p];
                    pin_oe[p]  = ~dir_q[p];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    input  logic              psp_mode,
    input  logic [WIDTH-1:0]  psp_dout,
    input  logic [WIDTH-1:0]  psp_oe
);
    logic [WIDTH-1:0] latch_q, dir_q, pins_sync;
    logic             rd_en;

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .latch_q_o (latch_q),
        .dir_q_o   (dir_q)
    );

    gpio_pin_mux #(.WIDTH(WIDTH)) i_mux (
        .psp_mode (psp_mode),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .psp_dout (psp_dout),
        .psp_oe   (psp_oe),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    always_comb begin
        rd_en     = bus_sel && !bus_wr;
        bus_rdata = '0;
        if (rd_en) begin
            unique case (reg_sel_e'(bus_addr))
                REG_PINS:  bus_rdata = pins_sync;
                REG_LATCH: bus_rdata = latch_q;
                REG_DIR:   bus_rdata = dir_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!psp_mode) |-> ((pin_oe & dir_q) == '0)); // R2
    AST_OUTPUT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!psp_mode) |-> ((pin_oe | dir_q) == '1 && pin_out == latch_q)); // R3
    AST_PSP_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        psp_mode |-> (pin_out == psp_dout && pin_oe == psp_oe)); // R7
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel || bus_wr) |-> (bus_rdata == '0)); // R10
    AST_LATCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == REG_LATCH) |-> (bus_rdata == latch_q)); // R4
endmodule

// File: tb/test_gpio_bidir_port.sv
`timescale 1ns/1ps
module test_gpio_bidir_port;
    logic       clk = 0, rst_n = 0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic [7:0] pin_in = 0, pin_out, pin_oe;
    logic       psp_mode = 0;
    logic [7:0] psp_dout = 0, psp_oe = 0;

    int  checks = 0, fails = 0;
    bit  done = 0;
    logic [7:0] m_latch, m_dir;

    always #10 clk = ~clk;

    gpio_bidir_port i_gpio_bidir_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .psp_mode(psp_mode), .psp_dout(psp_dout), .psp_oe(psp_oe)
    );

    function automatic logic [7:0] exp_oe(logic mode, logic [7:0] dir, logic [7:0] eoe);
        return mode ? eoe : ~dir;
    endfunction
    function automatic logic [7:0] exp_out(logic mode, logic [7:0] lat, logic [7:0] edat);
        return mode ? edat : lat;
    endfunction
    function automatic logic [7:0] exp_read(logic [1:0] a, logic [7:0] pins,
                                            logic [7:0] lat, logic [7:0] dir);
        case (a)
            2'd0:    return pins;
            2'd1:    return lat;
            2'd2:    return dir;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic sel, logic [1:0] a, logic [7:0] d);
        bus_sel = sel; bus_wr = 1; bus_addr = a; bus_wdata = d;
        if (sel) begin
            if (a == 2'd0 || a == 2'd1) m_latch = d;
            else if (a == 2'd2)         m_dir = d;
        end
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'h5EED1234));
        m_latch = 8'h00; m_dir = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        bus_read(2'd1, rd); chk("R1 latch", rd, 8'h00);
        bus_read(2'd2, rd); chk("R1 dir", rd, 8'hFF);

        // R11 mixed direction
        bus_write(1, 2'd2, 8'hCF);
        chk("R11 oe", pin_oe, 8'h30);
        chk("R2 oe", pin_oe & 8'hCF, 8'h00);

        // R3 / R4 latch drives and reads back against opposite pads
        bus_write(1, 2'd1, 8'hA5);
        pin_in = 8'h5A;
        idle(2);
        chk("R3 out", pin_out, 8'hA5);
        bus_read(2'd1, rd); chk("R4 latch read", rd, 8'hA5);
        bus_read(2'd0, rd); chk("R5 pins read", rd, 8'h5A);

        // R5 synchronizer depth
        pin_in = 8'h3C;
        idle(1);
        bus_read(2'd0, rd); chk("R5 one edge", rd, 8'h5A);
        idle(1);
        bus_read(2'd0, rd); chk("R5 two edges", rd, 8'h3C);

        // R6 write via pin address
        bus_write(1, 2'd0, 8'h0F);
        bus_read(2'd1, rd); chk("R6 latch via addr0", rd, 8'h0F);
        chk("R6 out", pin_out, 8'h0F);

        // R9 unused address
        bus_write(1, 2'd3, 8'hEE);
        bus_read(2'd3, rd); chk("R9 read", rd, 8'h00);
        bus_read(2'd1, rd); chk("R9 latch", rd, 8'h0F);
        bus_read(2'd2, rd); chk("R9 dir", rd, 8'hCF);

        // R10 unselected write, idle rdata
        bus_write(0, 2'd1, 8'hFF);
        bus_write(0, 2'd2, 8'h00);
        bus_read(2'd1, rd); chk("R10 latch", rd, 8'h0F);
        bus_read(2'd2, rd); chk("R10 dir", rd, 8'hCF);
        bus_addr = 2'd1; #1 chk("R10 rdata idle", bus_rdata, 8'h00);

        // R7 / R8 slave-port handover
        psp_mode = 1; psp_dout = 8'h99; psp_oe = 8'h0F;
        #1 chk("R7 out", pin_out, 8'h99);
        chk("R7 oe", pin_oe, 8'h0F);
        bus_write(1, 2'd1, 8'h11);
        bus_write(1, 2'd2, 8'h00);
        chk("R7 out held", pin_out, 8'h99);
        chk("R7 oe held", pin_oe, 8'h0F);
        psp_mode = 0;
        #1 chk("R8 out", pin_out, 8'h11);
        chk("R8 oe", pin_oe, 8'hFF);

        // Random mix, R2 R3 R6 R7 R8 R9 R10
        for (int i = 0; i < 400; i++) begin
            logic       sel;
            logic [1:0] a;
            logic [7:0] d;
            pin_in   = 8'($urandom);
            psp_mode = ($urandom_range(0, 3) == 0);
            psp_dout = 8'($urandom);
            psp_oe   = 8'($urandom);
            sel = ($urandom_range(0, 5) != 0);
            a   = 2'($urandom_range(0, 3));
            d   = 8'($urandom);
            bus_write(sel, a, d);
            idle(1);
            chk("R3/R7 rnd out", pin_out, exp_out(psp_mode, m_latch, psp_dout));
            chk("R2/R7 rnd oe", pin_oe, exp_oe(psp_mode, m_dir, psp_oe));
            a = 2'($urandom_range(0, 3));
            bus_read(a, rd);
            chk("R6/R9 rnd read", rd, exp_read(a, pin_in, m_latch, m_dir));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule